// File: doc/BRIEF.md
# Page-Mode Pseudo-SRAM Bus Controller

This block sits between an on-chip requester and an external asynchronous pseudo-SRAM with a 16-bit data bus. It drives the device's active-low chip, output, write and byte-lane enables and its 22-bit address. It turns user requests into correctly timed bus cycles. A request is a single read, a single write or a multi-word burst read. Every bus timing limit is a parameter counted in system clock cycles.

After reset the controller holds the device deselected for a parameterised power-up interval. Only then does it accept work. A burst read opens with one full random access. Each later word in the same sixteen-word page then needs only the short intrapage access time. The controller ends the run and starts again with a full access in two cases: the next word falls in a new page, or one more intrapage word would keep chip enable low past its maximum. Read data returns in order, one single-cycle strobe per word.

Top module: `psram_page_ctrl`

## Requirements
- R1: From reset release, `req_ready` stays low and `mem_ce_n` stays high for at least PWRUP_CYC clock cycles.
- R2: A read (`req_op` 2'b00, and 2'b11 treated the same way) drives `mem_ce_n`, `mem_oe_n` and the selected `mem_be_n` bits low with `mem_we_n` high. The address is held for RAND_CYC cycles, and the sampled word is returned on `rd_data` with `rd_valid`.
- R3: A write (`req_op` 2'b01) holds `mem_ce_n`, `mem_we_n` and the selected byte enables low for WR_CYC cycles with `mem_oe_n` high. Address and `mem_dq_o` stay unchanged, with `mem_dq_oe` high, through the cycle in which chip enable and write enable rise.
- R4: `req_be[0]` selects lane bits 7:0 (`mem_be_n[0]`) and `req_be[1]` selects bits 15:8 (`mem_be_n[1]`). A write changes only the selected lanes. On a read, unselected lanes of `rd_data` are zero.
- R5: A burst (`req_op` 2'b10) returns `req_len`+1 words from consecutive addresses. Within one page, chip enable stays low without a break. The first word takes RAND_CYC cycles and each further word PAGE_CYC cycles.
- R6: When the next burst word lies in a new sixteen-word page (the current address has its low four bits all ones), chip enable goes high for one cycle. The next word then gets a full RAND_CYC access. The address never leaves its page while chip enable stays low.
- R7: Chip enable never stays low for more than CEMAX_CYC consecutive cycles. A burst that would exceed this is split, and the words that remain restart with a full access.
- R8: `mem_dq_oe` is high only during writes. It is never high in a cycle where `mem_oe_n` is low or was low in the previous cycle.
- R9: `req_ready` is high only while the bus is idle, and a request is taken on `req_valid` and `req_ready`. Every requested read word produces exactly one `rd_valid` pulse, in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and accepting |
| req_op | input | 2 | 00 read, 01 write, 10 burst read, 11 read |
| req_addr | input | 22 | Word address |
| req_be | input | 2 | Byte lane select, bit 0 low lane |
| req_wdata | input | 16 | Write data |
| req_len | input | 8 | Burst word count minus one |
| rd_valid | output | 1 | One-cycle strobe per returned word |
| rd_data | output | 16 | Returned word, unselected lanes zero |
| mem_ce_n | output | 1 | Device chip enable, active low |
| mem_oe_n | output | 1 | Device output enable, active low |
| mem_we_n | output | 1 | Device write enable, active low |
| mem_be_n | output | 2 | Device byte enables, bit 0 low lane |
| mem_addr | output | 22 | Device address |
| mem_dq_o | output | 16 | Data toward the device |
| mem_dq_oe | output | 1 | Drive enable for the data bus |
| mem_dq_i | input | 16 | Data from the device |

## Verification
The hardest state to reach is a burst split by the chip-enable ceiling. It occurs only when a burst is long enough, stays inside one page, and the run reaches the limit before the page ends. The bench therefore shrinks the ceiling to twelve cycles and starts a ten-word burst at the base of a page. That forces exactly one mid-page split, whose restart the memory model must see as a fresh full-latency access. The bench's memory model returns a poison word whenever an access is shorter than its required latency, so any timing shortcut shows up in the scoreboard.

// File: rtl/psram_pkg.sv
package psram_pkg;
    typedef enum logic [1:0] {
        OP_RD     = 2'b00,
        OP_WR     = 2'b01,
        OP_BURST  = 2'b10,
        OP_RD_ALT = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        S_PWRUP,
        S_IDLE,
        S_RD,
        S_GAP,
        S_WR,
        S_WHOLD
    } state_e;
endpackage

// File: rtl/psram_timer.sv
module psram_timer #(
    parameter int W    = 8,
    parameter int INIT = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld,
    input  logic [W-1:0] ld_val,
    output logic         done
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ld)
            cnt_d = ld_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= W'(INIT);
        else        cnt_q <= cnt_d;
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/psram_ce_guard.sv
module psram_ce_guard #(
    parameter int CEMAX_CYC = 200,
    parameter int PAGE_CYC  = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    output logic room
);
    localparam int GW = $clog2(CEMAX_CYC + PAGE_CYC + 2) + 1;

    logic [GW-1:0] low_d, low_q;

    // low_q counts earlier low cycles of the current run; saturates at the ceiling
    always_comb begin
        low_d = low_q;
        if (ce_n)
            low_d = '0;
        else if (low_q < GW'(CEMAX_CYC))
            low_d = low_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) low_q <= '0;
        else        low_q <= low_d;
    end

    // current cycle plus one more intrapage access must still fit
    assign room = (low_q + GW'(PAGE_CYC + 1)) <= GW'(CEMAX_CYC);
endmodule

// File: rtl/psram_page_step.sv
module psram_page_step #(
    parameter int ADDR_W = 22,
    parameter int PAGE_W = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] nxt,
    output logic              page_last
);
    assign nxt       = addr + 1'b1;
    assign page_last = &addr[PAGE_W-1:0];
endmodule

// File: rtl/psram_page_ctrl.sv
module psram_page_ctrl #(
    parameter int ADDR_W    = 22,
    parameter int DATA_W    = 16,
    parameter int LEN_W     = 8,
    parameter int PAGE_W    = 4,
    parameter int PWRUP_CYC = 7500,
    parameter int RAND_CYC  = 4,
    parameter int PAGE_CYC  = 1,
    parameter int WR_CYC    = 4,
    parameter int CEMAX_CYC = 200
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [1:0]            req_op,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W/8-1:0]   req_be,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [LEN_W-1:0]      req_len,
    output logic                  rd_valid,
    output logic [DATA_W-1:0]     rd_data,
    output logic                  mem_ce_n,
    output logic                  mem_oe_n,
    output logic                  mem_we_n,
    output logic [DATA_W/8-1:0]   mem_be_n,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [DATA_W-1:0]     mem_dq_o,
    output logic                  mem_dq_oe,
    input  logic [DATA_W-1:0]     mem_dq_i
);
    import psram_pkg::*;

    localparam int BE_W = DATA_W / 8;
    localparam int M1   = (PWRUP_CYC > RAND_CYC) ? PWRUP_CYC : RAND_CYC;
    localparam int M2   = (M1 > WR_CYC) ? M1 : WR_CYC;
    localparam int M3   = (M2 > PAGE_CYC) ? M2 : PAGE_CYC;
    localparam int TW   = $clog2(M3 + 1);
    localparam logic [TW-1:0] LD_RAND = TW'(RAND_CYC - 1);
    localparam logic [TW-1:0] LD_PAGE = TW'(PAGE_CYC - 1);
    localparam logic [TW-1:0] LD_WR   = TW'(WR_CYC - 1);

    typedef struct packed {
        state_e            st;
        logic [ADDR_W-1:0] addr;
        logic [BE_W-1:0]   be;
        logic [BE_W-1:0]   be_n;
        logic [DATA_W-1:0] wdata;
        logic [LEN_W-1:0]  left;
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic              dq_oe;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t d, q;

    logic              tmr_ld;
    logic [TW-1:0]     tmr_val;
    logic              tmr_done;
    logic              ce_room;
    logic [ADDR_W-1:0] nxt_addr;
    logic              page_last;
    logic [DATA_W-1:0] lane_mask;

    psram_timer #(.W(TW), .INIT(PWRUP_CYC - 1)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (tmr_ld),
        .ld_val (tmr_val),
        .done   (tmr_done)
    );

    psram_ce_guard #(.CEMAX_CYC(CEMAX_CYC), .PAGE_CYC(PAGE_CYC)) u_guard (
        .clk   (clk),
        .rst_n (rst_n),
        .ce_n  (q.ce_n),
        .room  (ce_room)
    );

    psram_page_step #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_step (
        .addr      (q.addr),
        .nxt       (nxt_addr),
        .page_last (page_last)
    );

    for (genvar l = 0; l < BE_W; l++) begin : g_lane
        assign lane_mask[l*8 +: 8] = {8{q.be[l]}};
    end

    always_comb begin
        d        = q;
        d.rvalid = 1'b0;
        tmr_ld   = 1'b0;
        tmr_val  = '0;
        case (q.st)
            S_PWRUP: begin
                if (tmr_done) d.st = S_IDLE;
            end
            S_IDLE: begin
                if (req_valid) begin
                    d.addr  = req_addr;
                    d.be    = req_be;
                    d.be_n  = ~req_be;
                    d.wdata = req_wdata;
                    d.ce_n  = 1'b0;
                    tmr_ld  = 1'b1;
                    if (op_e'(req_op) == OP_WR) begin
                        d.st    = S_WR;
                        d.we_n  = 1'b0;
                        d.dq_oe = 1'b1;
                        d.left  = '0;
                        tmr_val = LD_WR;
                    end else begin
                        d.st    = S_RD;
                        d.oe_n  = 1'b0;
                        d.left  = (op_e'(req_op) == OP_BURST) ? req_len : '0;
                        tmr_val = LD_RAND;
                    end
                end
            end
            S_RD: begin
                if (tmr_done) begin
                    d.rdata  = mem_dq_i & lane_mask;
                    d.rvalid = 1'b1;
                    if (q.left == '0) begin
                        d.st   = S_IDLE;
                        d.ce_n = 1'b1;
                        d.oe_n = 1'b1;
                        d.be_n = '1;
                    end else begin
                        d.left = q.left - 1'b1;
                        d.addr = nxt_addr;
                        if (!page_last && ce_room) begin
                            tmr_ld  = 1'b1;
                            tmr_val = LD_PAGE;
                        end else begin
                            d.st   = S_GAP;
                            d.ce_n = 1'b1;
                            d.oe_n = 1'b1;
                            d.be_n = '1;
                        end
                    end
                end
            end
            S_GAP: begin
                d.st    = S_RD;
                d.ce_n  = 1'b0;
                d.oe_n  = 1'b0;
                d.be_n  = ~q.be;
                tmr_ld  = 1'b1;
                tmr_val = LD_RAND;
            end
            S_WR: begin
                if (tmr_done) begin
                    d.st   = S_WHOLD;
                    d.ce_n = 1'b1;
                    d.we_n = 1'b1;
                    d.be_n = '1;
                end
            end
            S_WHOLD: begin
                d.st    = S_IDLE;
                d.dq_oe = 1'b0;
            end
            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= S_PWRUP;
            q.ce_n   <= 1'b1;
            q.oe_n   <= 1'b1;
            q.we_n   <= 1'b1;
            q.be_n   <= '1;
        end else begin
            q <= d;
        end
    end

    assign req_ready = (q.st == S_IDLE);
    assign rd_valid  = q.rvalid;
    assign rd_data   = q.rdata;
    assign mem_ce_n  = q.ce_n;
    assign mem_oe_n  = q.oe_n;
    assign mem_we_n  = q.we_n;
    assign mem_be_n  = q.be_n;
    assign mem_addr  = q.addr;
    assign mem_dq_o  = q.wdata;
    assign mem_dq_oe = q.dq_oe;
endmodule

// File: rtl/psram_page_ctrl_chk.sv
module psram_page_ctrl_chk #(
    parameter int ADDR_W    = 22,
    parameter int DATA_W    = 16,
    parameter int PAGE_W    = 4,
    parameter int CEMAX_CYC = 200
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              mem_ce_n,
    input logic              mem_oe_n,
    input logic              mem_we_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_dq_o,
    input logic              mem_dq_oe
);
    int   run_q;
    logic seen_rdy_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q      <= 0;
            seen_rdy_q <= 1'b0;
        end else begin
            run_q      <= mem_ce_n ? 0 : run_q + 1;
            if (req_ready) seen_rdy_q <= 1'b1;
        end
    end

    AST_PWRUP_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_rdy_q && !req_ready) |-> mem_ce_n); // R1
    AST_READ_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (mem_we_n && !mem_ce_n)); // R2
    AST_WRITE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_oe_n && !mem_ce_n && mem_dq_oe)); // R3
    AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> ($stable(mem_addr) && $stable(mem_dq_o) && mem_dq_oe)); // R3
    AST_PAGE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && !$past(mem_ce_n) && mem_addr != $past(mem_addr))
        |-> (mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W]))); // R6
    AST_CE_CEILING: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_ce_n |-> (run_q < CEMAX_CYC)); // R7
    AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n))); // R8
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_dq_oe)); // R9
endmodule

bind psram_page_ctrl psram_page_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_W    (PAGE_W),
    .CEMAX_CYC (CEMAX_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .mem_ce_n  (mem_ce_n),
    .mem_oe_n  (mem_oe_n),
    .mem_we_n  (mem_we_n),
    .mem_addr  (mem_addr),
    .mem_dq_o  (mem_dq_o),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/tb_psram_page_ctrl.sv
module tb_psram_page_ctrl;
    localparam int AW = 22, DW = 16, LW = 8;
    localparam int PWR = 50, RAND = 4, PAGE = 2, WRC = 3, CEMAX = 12;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          req_valid, req_ready;
    logic [1:0]    req_op;
    logic [AW-1:0] req_addr;
    logic [1:0]    req_be;
    logic [DW-1:0] req_wdata;
    logic [LW-1:0] req_len;
    logic          rd_valid;
    logic [DW-1:0] rd_data;
    logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [1:0]    mem_be_n;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_o, mem_dq_i;

    psram_page_ctrl #(
        .ADDR_W(AW), .DATA_W(DW), .LEN_W(LW), .PAGE_W(4),
        .PWRUP_CYC(PWR), .RAND_CYC(RAND), .PAGE_CYC(PAGE),
        .WR_CYC(WRC), .CEMAX_CYC(CEMAX)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
        .req_len(req_len), .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_be_n(mem_be_n), .mem_addr(mem_addr), .mem_dq_o(mem_dq_o),
        .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
    );

    // device model and shadow copy
    logic [DW-1:0] mem [256];
    logic [DW-1:0] sh  [256];
    int            age = 0;
    bit            fresh = 1'b1;
    int            need;
    logic [AW-1:0] last_addr = '0;
    logic          prev_we_n = 1'b1;
    logic [1:0]    prev_be_n = 2'b11;

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i] = {8'(i) ^ 8'h5A, 8'(i)};
            sh[i]  = {8'(i) ^ 8'h5A, 8'(i)};
        end
    end

    always_comb begin
        need     = fresh ? RAND : PAGE;
        mem_dq_i = (!mem_ce_n && !mem_oe_n && age >= need) ? mem[mem_addr[7:0]] : 16'hBAD0;
    end

    always @(negedge clk) begin
        if (mem_ce_n || mem_oe_n) begin
            age   <= 0;
            fresh <= 1'b1;
        end else if (age != 0 && mem_addr != last_addr) begin
            age   <= 1;
            fresh <= 1'b0;
        end else begin
            age <= age + 1;
        end
        last_addr <= mem_addr;
        if (!prev_we_n && mem_we_n) begin
            for (int l = 0; l < 2; l++)
                if (!prev_be_n[l])
                    mem[mem_addr[7:0]][l*8 +: 8] <= mem_dq_oe ? mem_dq_o[l*8 +: 8] : 8'hEE;
        end
        prev_we_n <= mem_we_n;
        prev_be_n <= mem_be_n;
    end

    // bus statistics
    int   run_cur = 0, last_run = 0, max_run = 0, ce_falls = 0;
    int   turn_viol = 0, pwr_viol = 0;
    bit   ready_seen = 1'b0;
    logic prev_ce_n = 1'b1, prev_oe_n = 1'b1;

    always @(negedge clk) begin
        if (rst_n && req_ready) ready_seen = 1'b1;
        if (!ready_seen && !mem_ce_n) pwr_viol++;
        if (mem_dq_oe && (!mem_oe_n || !prev_oe_n)) turn_viol++;
        prev_oe_n = mem_oe_n;
        if (!mem_ce_n) begin
            if (prev_ce_n) ce_falls++;
            run_cur++;
            if (run_cur > max_run) max_run = run_cur;
        end else begin
            if (!prev_ce_n) last_run = run_cur;
            run_cur = 0;
        end
        prev_ce_n = mem_ce_n;
    end

    task automatic clr_stats();
        ce_falls = 0;
        max_run  = 0;
        last_run = 0;
    endtask

    // checking
    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string r, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
        end
    endtask

    // scoreboard
    logic [DW-1:0] exp_q[$];
    string         tag_q[$];
    int            n_push = 0, n_pop = 0;

    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9 unexpected rd_valid", longint'(rd_data), 0);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_pop++;
                chk(rd_data == e, t, longint'(rd_data), longint'(e));
            end
        end
    end

    task automatic issue(input logic [1:0] op, input int a, input logic [1:0] be,
                         input logic [DW-1:0] wd, input int len, input string tag);
        logic [DW-1:0] m;
        int n;
        m = {{8{be[1]}}, {8{be[0]}}};
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = op;
        req_addr  = AW'(a);
        req_be    = be;
        req_wdata = wd;
        req_len   = LW'(len);
        while (!req_ready) @(negedge clk);
        if (op == 2'b01) begin
            for (int l = 0; l < 2; l++)
                if (be[l]) sh[a & 255][l*8 +: 8] = wd[l*8 +: 8];
        end else begin
            n = (op == 2'b10) ? len + 1 : 1;
            for (int k = 0; k < n; k++) begin
                exp_q.push_back(sh[(a + k) & 255] & m);
                tag_q.push_back(tag);
                n_push++;
            end
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R9 ready low while busy", longint'(req_ready), 0);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 20000, 0);
        finish_run();
    end

    initial begin
        int cyc;
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_addr = '0;
        req_be = '0; req_wdata = '0; req_len = '0;
        repeat (5) @(negedge clk);
        chk(!req_ready && mem_ce_n, "R1 reset state", {req_ready, mem_ce_n}, 2'b01);
        rst_n = 1'b1;
        cyc = 0;
        while (!req_ready) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc >= PWR, "R1 power-up wait", cyc, PWR);
        chk(pwr_viol == 0, "R1 chip enable during power-up", pwr_viol, 0);

        // R2 single reads
        issue(2'b00, 5, 2'b11, '0, 0, "R2 single read");
        issue(2'b11, 9, 2'b11, '0, 0, "R2 read via op 11");
        // R3 write then read back
        issue(2'b01, 5, 2'b11, 16'h1234, 0, "R3");
        issue(2'b00, 5, 2'b11, '0, 0, "R3 write readback");
        // R4 byte lanes
        issue(2'b01, 6, 2'b01, 16'hABCD, 0, "R4");
        issue(2'b01, 7, 2'b10, 16'h5566, 0, "R4");
        issue(2'b00, 6, 2'b11, '0, 0, "R4 lower-lane write");
        issue(2'b00, 7, 2'b11, '0, 0, "R4 upper-lane write");
        issue(2'b00, 8, 2'b01, '0, 0, "R4 upper lane zero on read");

        // R5 burst inside one page
        clr_stats();
        issue(2'b10, 16, 2'b11, '0, 3, "R5 burst data");
        chk(ce_falls == 1, "R5 single chip-enable run", ce_falls, 1);
        chk(last_run == RAND + 3 * PAGE, "R5 burst run length", last_run, RAND + 3 * PAGE);

        // R6 burst crossing a page
        clr_stats();
        issue(2'b10, 30, 2'b11, '0, 3, "R6 page crossing data");
        chk(ce_falls == 2, "R6 restart at new page", ce_falls, 2);

        // R7 burst split by the ceiling
        clr_stats();
        issue(2'b10, 64, 2'b11, '0, 9, "R7 split burst data");
        chk(ce_falls == 2, "R7 split count", ce_falls, 2);
        chk(max_run == CEMAX, "R7 longest run", max_run, CEMAX);

        // R8 read followed at once by write
        issue(2'b00, 65, 2'b11, '0, 0, "R8 read before write");
        issue(2'b01, 65, 2'b11, 16'hC3C3, 0, "R8");
        issue(2'b00, 65, 2'b11, '0, 0, "R8 readback after turnaround");
        chk(turn_viol == 0, "R8 bus contention", turn_viol, 0);

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0 && n_pop == n_push, "R9 word count", n_pop, n_push);
        finish_run();
    end
endmodule